// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block sits between a PC host bus and a small embedded keyboard-controller processor. The host writes bytes into an input buffer and reads either an output buffer or a status byte. One address line tells commands from data on writes, and status from data on reads. The embedded processor takes bytes out of the input buffer, writes bytes into the output buffer, and watches the status flags that record who owns each buffer.

The processor also owns an 8-bit general output port. Four of its bits drive the pull-downs of the open-drain keyboard and mouse clock and data lines, with inverted sense. Three of those lines come back to the processor through synchronisers. One bit drives the A20 gate output, and two bits control the keyboard and mouse interrupt lines. A one-way "flag mode" command changes what those two interrupt bits mean. Before the command, the bits drive the interrupts directly. After it, they only enable the buffer flags onto the interrupts.

Top module: `kbc_host_if`

## Requirements
- R1: A host write puts host_wdata into the input buffer and sets status bit 1 (input full). A processor read of the input buffer clears bit 1. When both happen in the same cycle, the write wins and the bit stays set.
- R2: A host write copies host_a2 into status bit 3 (1 means command, 0 means data). Host reads do not change bit 3.
- R3: A processor write to the output buffer stores its byte and sets status bit 0 (output full). A host read with host_a2=0 returns the output buffer and clears bit 0. When a processor write falls in the same cycle, bit 0 stays set.
- R4: A host read with host_a2=1 returns the status byte and leaves bit 0 unchanged. host_rdata is updated on the clock edge that samples host_rd and holds its value until the next read. Status bits 2 and 4 to 7 read as 0.
- R5: While flag mode is off, kbd_irq equals port bit 4 and aux_irq equals port bit 5.
- R6: While flag mode is on, kbd_irq equals port bit 4 AND status bit 0. aux_irq equals port bit 5 AND NOT status bit 1.
- R7: A pulse on cpu_flags_cmd turns flag mode on. Flag mode stays on through any later activity, including further pulses, and only reset turns it off.
- R8: kclk_pull equals NOT port bit 6, kdat_pull equals NOT port bit 7, mclk_pull equals NOT port bit 3, and mdat_pull equals NOT port bit 2. gate_a20 equals port bit 1.
- R9: kclk_sense, kdat_sense and mclk_sense follow kclk_in, kdat_in and mclk_in after SYNC_STAGES clock edges. All three are 1 during reset.
- R10: After synchronous reset, both buffers, the status byte and host_rdata are 0, the port reads 8'hCF, and both interrupts are 0.
- R11: A processor port write loads cpu_p2_wdata into the port, and cpu_p2 returns the value. All state and the interrupt outputs change on the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a2 | input | 1 | Address select: 1 command/status, 0 data |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Registered host read byte |
| cpu_ibuf_rd | input | 1 | Processor read of input buffer |
| cpu_ibuf_data | output | DW | Input buffer contents |
| cpu_obuf_wr | input | 1 | Processor write to output buffer |
| cpu_obuf_wdata | input | DW | Output buffer write byte |
| cpu_status | output | DW | Status byte |
| cpu_p2_wr | input | 1 | Port write strobe |
| cpu_p2_wdata | input | DW | Port write byte |
| cpu_p2 | output | DW | Port contents |
| cpu_flags_cmd | input | 1 | Enter flag mode |
| kclk_sense | output | 1 | Synchronised keyboard clock line |
| kdat_sense | output | 1 | Synchronised keyboard data line |
| mclk_sense | output | 1 | Synchronised mouse clock line |
| kbd_irq | output | 1 | Keyboard interrupt |
| aux_irq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | A20 gate |
| kclk_pull | output | 1 | Pull keyboard clock low |
| kdat_pull | output | 1 | Pull keyboard data low |
| mclk_pull | output | 1 | Pull mouse clock low |
| mdat_pull | output | 1 | Pull mouse data low |
| kclk_in | input | 1 | Keyboard clock line level |
| kdat_in | input | 1 | Keyboard data line level |
| mclk_in | input | 1 | Mouse clock line level |

## Verification
The bench drives strobes into the same cycle to test the collision rules. A design that let a clear win over a set would drop a full flag, and a host status read would then lose the processor's new byte. It toggles the port's interrupt bits before and after flag mode, and fires the mode command again. A mode that was not sticky, or an interrupt taken straight from the port while in flag mode, shows up as a wrong interrupt level. A reset in the middle of the run checks that flag mode clears, and toggling the line inputs checks that the readbacks arrive after exactly the synchroniser depth.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  // status byte bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;
  // port bit roles
  localparam int P2_A20  = 1;
  localparam int P2_MDAT = 2;
  localparam int P2_MCLK = 3;
  localparam int P2_KIRQ = 4;
  localparam int P2_MIRQ = 5;
  localparam int P2_KCLK = 6;
  localparam int P2_KDAT = 7;
  // lines released, interrupt enables low
  localparam logic [7:0] P2_RESET = 8'hCF;
endpackage

// File: rtl/kbc_xfer_regs.sv
module kbc_xfer_regs
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_a2,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cpu_ibuf_rd,
  output logic [DW-1:0] cpu_ibuf_data,
  input  logic          cpu_obuf_wr,
  input  logic [DW-1:0] cpu_obuf_wdata,
  output logic [DW-1:0] status,
  output logic          obf_nx,
  output logic          ibf_nx
);
  logic [DW-1:0] ibuf_q, obuf_q, rdata_q;
  logic          obf_q, ibf_q, cmd_q;

  // set beats clear on both flags
  always_comb begin
    ibf_nx = ibf_q;
    if (host_wr)          ibf_nx = 1'b1;
    else if (cpu_ibuf_rd) ibf_nx = 1'b0;
    obf_nx = obf_q;
    if (cpu_obuf_wr)                obf_nx = 1'b1;
    else if (host_rd && !host_a2)   obf_nx = 1'b0;
  end

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf_q;
    status[ST_IBF] = ibf_q;
    status[ST_CMD] = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf_q  <= '0;
      obuf_q  <= '0;
      rdata_q <= '0;
      obf_q   <= 1'b0;
      ibf_q   <= 1'b0;
      cmd_q   <= 1'b0;
    end else begin
      if (host_rd)     rdata_q <= host_a2 ? status : obuf_q;
      if (host_wr) begin
        ibuf_q <= host_wdata;
        cmd_q  <= host_a2;
      end
      if (cpu_obuf_wr) obuf_q <= cpu_obuf_wdata;
      obf_q <= obf_nx;
      ibf_q <= ibf_nx;
    end
  end

  assign host_rdata    = rdata_q;
  assign cpu_ibuf_data = ibuf_q;
endmodule

// File: rtl/kbc_port2.sv
module kbc_port2
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] p2_q,
  output logic [DW-1:0] p2_nx
);
  assign p2_nx = wr ? wdata : p2_q;

  always_ff @(posedge clk) begin
    if (rst) p2_q <= DW'(P2_RESET);
    else     p2_q <= p2_nx;
  end
endmodule

// File: rtl/kbc_irq_ctl.sv
module kbc_irq_ctl
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flags_cmd,
  input  logic [DW-1:0] p2_nx,
  input  logic          obf_nx,
  input  logic          ibf_nx,
  output logic          flags_on,
  output logic          kbd_irq,
  output logic          aux_irq
);
  logic flags_q, flags_nx, kirq_q, mirq_q;

  assign flags_nx = flags_q | flags_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= 1'b0;
      kirq_q  <= 1'b0;
      mirq_q  <= 1'b0;
    end else begin
      flags_q <= flags_nx;
      kirq_q  <= p2_nx[P2_KIRQ] & (flags_nx ? obf_nx  : 1'b1);
      mirq_q  <= p2_nx[P2_MIRQ] & (flags_nx ? ~ibf_nx : 1'b1);
    end
  end

  assign flags_on = flags_q;
  assign kbd_irq  = kirq_q;
  assign aux_irq  = mirq_q;
endmodule

// File: rtl/kbc_line_sync.sv
module kbc_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_a2,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cpu_ibuf_rd,
  output logic [DW-1:0] cpu_ibuf_data,
  input  logic          cpu_obuf_wr,
  input  logic [DW-1:0] cpu_obuf_wdata,
  output logic [DW-1:0] cpu_status,
  input  logic          cpu_p2_wr,
  input  logic [DW-1:0] cpu_p2_wdata,
  output logic [DW-1:0] cpu_p2,
  input  logic          cpu_flags_cmd,
  output logic          kclk_sense,
  output logic          kdat_sense,
  output logic          mclk_sense,
  output logic          kbd_irq,
  output logic          aux_irq,
  output logic          gate_a20,
  output logic          kclk_pull,
  output logic          kdat_pull,
  output logic          mclk_pull,
  output logic          mdat_pull,
  input  logic          kclk_in,
  input  logic          kdat_in,
  input  logic          mclk_in
);
  localparam int NLINES = 3;

  logic [DW-1:0]     p2_q, p2_nx;
  logic              obf_nx, ibf_nx, flags_on;
  logic [NLINES-1:0] sense;

  kbc_xfer_regs #(.DW(DW)) xfer_i (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_a2(host_a2),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_ibuf_data(cpu_ibuf_data),
    .cpu_obuf_wr(cpu_obuf_wr), .cpu_obuf_wdata(cpu_obuf_wdata),
    .status(cpu_status), .obf_nx(obf_nx), .ibf_nx(ibf_nx)
  );

  kbc_port2 #(.DW(DW)) port_i (
    .clk(clk), .rst(rst), .wr(cpu_p2_wr), .wdata(cpu_p2_wdata),
    .p2_q(p2_q), .p2_nx(p2_nx)
  );

  kbc_irq_ctl #(.DW(DW)) irq_i (
    .clk(clk), .rst(rst), .flags_cmd(cpu_flags_cmd), .p2_nx(p2_nx),
    .obf_nx(obf_nx), .ibf_nx(ibf_nx), .flags_on(flags_on),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  kbc_line_sync #(.STAGES(SYNC_STAGES), .W(NLINES)) sync_i (
    .clk(clk), .rst(rst), .d({mclk_in, kdat_in, kclk_in}), .q(sense)
  );

  assign cpu_p2     = p2_q;
  assign gate_a20   = p2_q[P2_A20];
  assign kclk_pull  = ~p2_q[P2_KCLK];
  assign kdat_pull  = ~p2_q[P2_KDAT];
  assign mclk_pull  = ~p2_q[P2_MCLK];
  assign mdat_pull  = ~p2_q[P2_MDAT];
  assign kclk_sense = sense[0];
  assign kdat_sense = sense[1];
  assign mclk_sense = sense[2];
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic          host_rd,
  input logic          host_a2,
  input logic          cpu_ibuf_rd,
  input logic          cpu_obuf_wr,
  input logic [DW-1:0] cpu_status,
  input logic [DW-1:0] cpu_p2,
  input logic          flags_on,
  input logic          kbd_irq,
  input logic          aux_irq
);
  p_ibf_set_r1: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> cpu_status[ST_IBF]);
  p_ibf_clr_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_ibuf_rd && !host_wr |=> !cpu_status[ST_IBF]);
  p_cmd_bit_r2: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> cpu_status[ST_CMD] == $past(host_a2));
  p_obf_set_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_obuf_wr |=> cpu_status[ST_OBF]);
  p_obf_clr_r3: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_a2 && !cpu_obuf_wr |=> !cpu_status[ST_OBF]);
  p_stat_rd_r4: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_a2 && !cpu_obuf_wr |=> $stable(cpu_status[ST_OBF]));
  p_kirq_port_r5: assert property (@(posedge clk) disable iff (rst)
    !flags_on |-> kbd_irq == cpu_p2[P2_KIRQ]);
  p_mirq_port_r5: assert property (@(posedge clk) disable iff (rst)
    !flags_on |-> aux_irq == cpu_p2[P2_MIRQ]);
  p_kirq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    flags_on |-> kbd_irq == (cpu_p2[P2_KIRQ] & cpu_status[ST_OBF]));
  p_mirq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    flags_on |-> aux_irq == (cpu_p2[P2_MIRQ] & !cpu_status[ST_IBF]));
  p_flags_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    flags_on |=> flags_on);
endmodule

bind kbc_host_if kbc_host_if_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_a2(host_a2), .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_obuf_wr(cpu_obuf_wr),
  .cpu_status(cpu_status), .cpu_p2(cpu_p2), .flags_on(flags_on),
  .kbd_irq(kbd_irq), .aux_irq(aux_irq)
);

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb_top;
  localparam int CLK_NS = 10;
  localparam int SYNC   = 2;

  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0, host_a2 = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic cpu_ibuf_rd = 0, cpu_obuf_wr = 0, cpu_p2_wr = 0, cpu_flags_cmd = 0;
  logic [7:0] cpu_ibuf_data, cpu_obuf_wdata = 0, cpu_status, cpu_p2_wdata = 0, cpu_p2;
  logic kclk_sense, kdat_sense, mclk_sense, kbd_irq, aux_irq, gate_a20;
  logic kclk_pull, kdat_pull, mclk_pull, mdat_pull;
  logic kclk_in = 1, kdat_in = 1, mclk_in = 1;

  int n_cmp = 0, n_bad = 0;
  bit started = 0;

  kbc_host_if #(.DW(8), .SYNC_STAGES(SYNC)) dut_i (.*);

  always #(CLK_NS/2) clk = ~clk;

  // reference model
  logic [7:0] m_ibuf, m_obuf, m_rdata, m_p2;
  bit m_ibf, m_obf, m_cmd, m_flags, m_kirq, m_mirq;
  bit q_kc[$], q_kd[$], q_mc[$];

  function automatic logic [7:0] m_status();
    return {4'b0, m_cmd, 1'b0, m_ibf, m_obf};
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_ibuf = 0; m_obuf = 0; m_rdata = 0; m_p2 = 8'hCF;
      m_ibf = 0; m_obf = 0; m_cmd = 0; m_flags = 0; m_kirq = 0; m_mirq = 0;
      q_kc = {}; q_kd = {}; q_mc = {};
      for (int i = 0; i < SYNC; i++) begin
        q_kc.push_back(1); q_kd.push_back(1); q_mc.push_back(1);
      end
    end else begin
      if (host_rd) m_rdata = host_a2 ? m_status() : m_obuf;
      if (host_wr) begin m_ibuf = host_wdata; m_ibf = 1; m_cmd = host_a2; end
      else if (cpu_ibuf_rd) m_ibf = 0;
      if (cpu_obuf_wr) begin m_obuf = cpu_obuf_wdata; m_obf = 1; end
      else if (host_rd && !host_a2) m_obf = 0;
      if (cpu_p2_wr) m_p2 = cpu_p2_wdata;
      if (cpu_flags_cmd) m_flags = 1;
      if (m_flags) begin
        m_kirq = m_p2[4] && m_obf;
        m_mirq = m_p2[5] && !m_ibf;
      end else begin
        m_kirq = m_p2[4];
        m_mirq = m_p2[5];
      end
      q_kc.push_back(kclk_in); void'(q_kc.pop_front());
      q_kd.push_back(kdat_in); void'(q_kd.pop_front());
      q_mc.push_back(mclk_in); void'(q_mc.pop_front());
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(rst ? "R10" : "R3/R4", "host_rdata", host_rdata, m_rdata);
    chk(rst ? "R10" : "R1/R2/R3", "cpu_status", cpu_status, m_status());
    chk("R1", "cpu_ibuf_data", cpu_ibuf_data, m_ibuf);
    chk(rst ? "R10" : "R11", "cpu_p2", cpu_p2, m_p2);
    chk(m_flags ? "R6" : "R5", "kbd_irq", {7'b0, kbd_irq}, {7'b0, m_kirq});
    chk(m_flags ? "R6" : "R5", "aux_irq", {7'b0, aux_irq}, {7'b0, m_mirq});
    chk("R8", "pulls_a20", {3'b0, gate_a20, kclk_pull, kdat_pull, mclk_pull, mdat_pull},
        {3'b0, m_p2[1], !m_p2[6], !m_p2[7], !m_p2[3], !m_p2[2]});
    chk("R9", "sense", {5'b0, mclk_sense, kdat_sense, kclk_sense},
        {5'b0, q_mc[0], q_kd[0], q_kc[0]});
  end

  task automatic idle();
    host_wr = 0; host_rd = 0; cpu_ibuf_rd = 0; cpu_obuf_wr = 0;
    cpu_p2_wr = 0; cpu_flags_cmd = 0;
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3); rst = 0; tick(1);
    // R5: direct interrupt control before flag mode
    cpu_p2_wr = 1; cpu_p2_wdata = 8'hFF; tick(2);
    cpu_p2_wr = 1; cpu_p2_wdata = 8'h10; tick(2);
    // R1/R2: command then data writes, processor read
    host_wr = 1; host_a2 = 1; host_wdata = 8'hD1; tick(1);
    cpu_ibuf_rd = 1; tick(1);
    host_wr = 1; host_a2 = 0; host_wdata = 8'h5A; tick(1);
    host_wr = 1; cpu_ibuf_rd = 1; host_wdata = 8'h3C; tick(2);  // R1 collision
    // R3/R4: output buffer, status read, data read
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'hA7; tick(1);
    host_rd = 1; host_a2 = 1; tick(1);
    host_rd = 1; host_a2 = 0; tick(1);
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h42; host_rd = 1; host_a2 = 0; tick(2); // R3 collision
    // R6/R7: flag mode
    cpu_p2_wr = 1; cpu_p2_wdata = 8'h30; cpu_flags_cmd = 1; tick(2);
    host_rd = 1; host_a2 = 0; tick(1);
    cpu_ibuf_rd = 1; tick(1);
    cpu_flags_cmd = 1; tick(1);
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h01; tick(1);
    cpu_p2_wr = 1; cpu_p2_wdata = 8'h00; tick(1);
    // R8/R9: line patterns
    for (int i = 0; i < 8; i++) begin
      cpu_p2_wr = 1; cpu_p2_wdata = 8'(i * 37);
      {mclk_in, kdat_in, kclk_in} = 3'(i);
      tick(1);
    end
    tick(3);
    // mid-run reset clears flag mode (R7, R10)
    rst = 1; tick(2); rst = 0;
    cpu_p2_wr = 1; cpu_p2_wdata = 8'h10; tick(2);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      host_wr = ($urandom % 4) == 0; host_rd = ($urandom % 4) == 0;
      host_a2 = $urandom; host_wdata = $urandom;
      cpu_ibuf_rd = ($urandom % 3) == 0; cpu_obuf_wr = ($urandom % 4) == 0;
      cpu_obuf_wdata = $urandom; cpu_p2_wr = ($urandom % 6) == 0;
      cpu_p2_wdata = $urandom; cpu_flags_cmd = ($urandom % 150) == 0;
      kclk_in = $urandom; kdat_in = $urandom; mclk_in = $urandom;
      @(negedge clk); #1;
    end
    idle(); tick(4);
    summary();
  end
endmodule